// File: doc/BRIEF.md
# Range Translation Buffer with Reserved Block Slots

This block is a small fully associative translation buffer. Each entry maps a virtual range of variable size onto a physical base address. Lookup is combinational: a virtual address presented on the lookup port yields, in the same cycle, a hit flag, the index of the matching entry, the translated physical address and the rights fields stored with that entry. Rights checking is left to a neighbouring block, which receives those fields.

The low `NB` slots are reserved block slots. They are written and removed only by the forced block commands. Range purges, the purge-all command and the replacement policy never touch them. All other slots are general slots, filled by two insert styles. The one-shot sized insert creates an entry covering a power-of-four multiple of the page size. The two-step legacy insert records a pending single page and commits it only when a matching protection step follows.

All updates arrive on one command port that carries an opcode and its operands. One command is accepted per cycle, and its effect becomes visible from the next cycle on.

Top module: `range_tlb`

## Requirements
- R1: A lookup hits entry i when i is valid and start(i) <= lk_va <= last(i). If several entries hit, the lowest index wins. `lk_pa` = base(i) + (lk_va - start(i)). On a miss, `lk_hit`, `lk_idx`, `lk_pa` and all rights outputs are zero. `lk_flags` is {T,D,B,U} with T in bit 3.
- R2: Sized insert (opcode 3). The size code k is cmd_aux[3:0] and the span is 4096<<(2k) bytes, saturating to the whole space. Start is cmd_va aligned down to the span and last is start+span-1. The base is {cmd_aux[24:5], 12'h000} aligned down to the span.
- R3: Before any insert, every valid general slot whose range overlaps the new range is invalidated. Block slots are kept.
- R4: A new general entry goes into the lowest-index invalid general slot. If every general slot is valid, it goes into the slot named by a rotating pointer. The pointer starts at NB, advances only when used and wraps from the last slot back to NB.
- R5: Legacy address step (opcode 1). It records the page holding cmd_va and base {cmd_aux[24:5], 12'h000}, and creates no valid entry. The legacy protection step (opcode 2) commits that page only if cmd_va lies in the pending page. Either way the pending record is consumed.
- R6: The legacy rights word is cmd_word[31:0]. Access id is bits 18:1, U bit 19, PL2 bits 21:20, PL1 bits 23:22, type bits 26:24, B bit 27, D bit 28, T bit 29.
- R7: The sized-insert rights word is cmd_word[63:0]. T is bit 61, D bit 60, B bit 59, type bits 58:56, PL1 bits 55:54, PL2 bits 53:52, U bit 51, access id bits 31:1.
- R8: Range purge (opcode 4). The range starts at the page of cmd_va and spans 4096<<(2*cmd_va[3:0]) bytes. It invalidates the overlapping general slots only.
- R9: Purge-all (opcode 5) invalidates every general slot, sets the pointer to NB and cancels a pending legacy step. Block slots are unchanged.
- R10: Block insert (opcode 6) with cmd_slot < NB overwrites that slot. The range starts at the page of cmd_va and spans cmd_len pages (cmd_len >= 1). The base is {cmd_aux[19:0], 12'h000}. Rights use the R6 layout with T forced to 0 and D forced to 1.
- R11: Block purge (opcode 7) with cmd_slot < NB invalidates that slot. For opcode 6 or 7 with cmd_slot >= NB, `cmd_err` is 1 in that cycle and no entry changes.
- R12: A command takes effect at the next rising edge. A lookup in the same cycle sees the prior contents. Opcode 0 is no operation.
- R13: After reset, all entries are invalid, no legacy step is pending and the pointer is NB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode |
| cmd_va | input | ADDR_W | Virtual address operand |
| cmd_aux | input | 32 | Size code and page operand |
| cmd_word | input | 64 | Rights word |
| cmd_slot | input | IDX_W | Block slot number |
| cmd_len | input | LEN_W | Block length in pages |
| cmd_err | output | 1 | Bad block slot |
| lk_va | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Matching entry index |
| lk_pa | output | ADDR_W | Translated address |
| lk_acc_id | output | 31 | Access id of the hit |
| lk_type | output | 3 | Access type of the hit |
| lk_pl1 | output | 2 | First privilege field |
| lk_pl2 | output | 2 | Second privilege field |
| lk_flags | output | 4 | {T,D,B,U} of the hit |

## Verification
A lookup and a command that rewrites the entry under that lookup can fall in the same cycle. The bench provokes this by setting `lk_va` to the range being inserted, purged or block-written while the command is on the port. The reference model is updated only after the comparison, so a correct design must report the old translation in that cycle and the new one in the next. The same holds for a flush that retires an entry while it is being looked up.

// File: rtl/rtlb_pkg.sv
`timescale 1ns/1ps
package rtlb_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LEG_ADDR  = 3'd1,
    OP_LEG_PROT  = 3'd2,
    OP_SIZED     = 3'd3,
    OP_PURGE     = 3'd4,
    OP_PURGE_ALL = 3'd5,
    OP_BLK_INS   = 3'd6,
    OP_BLK_PURGE = 3'd7
  } op_e;

  typedef struct packed {
    logic [30:0] acc;
    logic        u;
    logic [1:0]  pl2;
    logic [1:0]  pl1;
    logic [2:0]  typ;
    logic        b;
    logic        d;
    logic        t;
  } rights_t;

  function automatic rights_t from_legacy(input logic [31:0] w);
    rights_t r;
    r.acc = {13'd0, w[18:1]};
    r.u   = w[19];
    r.pl2 = w[21:20];
    r.pl1 = w[23:22];
    r.typ = w[26:24];
    r.b   = w[27];
    r.d   = w[28];
    r.t   = w[29];
    return r;
  endfunction

  function automatic rights_t from_sized(input logic [63:0] w);
    rights_t r;
    r.acc = w[31:1];
    r.u   = w[51];
    r.pl2 = w[53:52];
    r.pl1 = w[55:54];
    r.typ = w[58:56];
    r.b   = w[59];
    r.d   = w[60];
    r.t   = w[61];
    return r;
  endfunction

endpackage

// File: rtl/rtlb_rst_sync.sv
`timescale 1ns/1ps
module rtlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rtlb_decode.sv
`timescale 1ns/1ps
module rtlb_decode
  import rtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = 16
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] cmd_va,
  input  logic [31:0]       cmd_aux,
  input  logic [63:0]       cmd_word,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              pend_q,
  input  logic [ADDR_W-1:0] pend_start,
  input  logic [ADDR_W-1:0] pend_pa,
  output logic [ADDR_W-1:0] r_start,
  output logic [ADDR_W-1:0] r_last,
  output logic [ADDR_W-1:0] w_pa,
  output rights_t           w_rt,
  output logic              prot_match
);
  localparam int PPN_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] PG_MASK = {{PPN_W{1'b0}}, {PAGE_BITS{1'b1}}};

  function automatic logic [ADDR_W-1:0] span_mask(input logic [3:0] k);
    int sb;
    sb = PAGE_BITS + 2 * int'(k);
    if (sb >= ADDR_W) return {ADDR_W{1'b1}};
    return {ADDR_W{1'b1}} >> (ADDR_W - sb);
  endfunction

  logic [ADDR_W-1:0] va_page, aux_pa, blk_pa, m_sz, m_pg, len_bytes;
  logic [ADDR_W:0]   purge_sum;
  logic              unused_dec;

  assign va_page    = cmd_va & ~PG_MASK;
  assign aux_pa     = {cmd_aux[PPN_W+4:5], {PAGE_BITS{1'b0}}};
  assign blk_pa     = {cmd_aux[PPN_W-1:0], {PAGE_BITS{1'b0}}};
  assign m_sz       = span_mask(cmd_aux[3:0]);
  assign m_pg       = span_mask(cmd_va[3:0]);
  assign purge_sum  = {1'b0, va_page} + {1'b0, m_pg};
  assign len_bytes  = {{(ADDR_W-LEN_W){1'b0}}, cmd_len} << PAGE_BITS;
  assign prot_match = pend_q && (va_page == pend_start);
  assign unused_dec = ^{cmd_aux[31:PPN_W+5]};

  always_comb begin
    r_start = va_page;
    r_last  = va_page | PG_MASK;
    w_pa    = aux_pa;
    w_rt    = from_legacy(cmd_word[31:0]);
    unique case (op)
      OP_LEG_PROT: begin
        r_start = pend_start;
        r_last  = pend_start | PG_MASK;
        w_pa    = pend_pa;
      end
      OP_SIZED: begin
        r_start = cmd_va & ~m_sz;
        r_last  = (cmd_va & ~m_sz) | m_sz;
        w_pa    = aux_pa & ~m_sz;
        w_rt    = from_sized(cmd_word);
      end
      OP_PURGE: begin
        r_last = purge_sum[ADDR_W] ? {ADDR_W{1'b1}} : purge_sum[ADDR_W-1:0];
      end
      OP_BLK_INS: begin
        r_last = va_page + len_bytes - 1'b1;
        w_pa   = blk_pa;
        w_rt.t = 1'b0;
        w_rt.d = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rtlb_match.sv
`timescale 1ns/1ps
module rtlb_match
  import rtlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NE     = 16,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [NE-1:0]     vld,
  input  logic [ADDR_W-1:0] e_start [NE],
  input  logic [ADDR_W-1:0] e_last  [NE],
  input  logic [ADDR_W-1:0] e_pa    [NE],
  input  rights_t           e_rt    [NE],
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] pa,
  output rights_t           rt
);
  logic [NE-1:0]    hit_v;
  logic [IDX_W-1:0] sel;
  logic             any;

  for (genvar g = 0; g < NE; g++) begin : g_cmp
    assign hit_v[g] = vld[g] && (va >= e_start[g]) && (va <= e_last[g]);
  end

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  assign hit = any;
  assign idx = any ? sel : '0;
  assign pa  = any ? (e_pa[sel] + (va - e_start[sel])) : '0;
  assign rt  = any ? e_rt[sel] : '0;
endmodule

// File: rtl/rtlb_alloc.sv
`timescale 1ns/1ps
module rtlb_alloc #(
  parameter int ADDR_W = 32,
  parameter int NE     = 16,
  parameter int NB     = 4,
  parameter int IDX_W  = 4
) (
  input  logic [NE-1:0]     vld,
  input  logic [ADDR_W-1:0] e_start [NE],
  input  logic [ADDR_W-1:0] e_last  [NE],
  input  logic [ADDR_W-1:0] r_start,
  input  logic [ADDR_W-1:0] r_last,
  input  logic              flush_en,
  input  logic [IDX_W-1:0]  rr_q,
  output logic [NE-1:0]     kept,
  output logic [IDX_W-1:0]  victim,
  output logic              use_rr,
  output logic [IDX_W-1:0]  rr_next
);
  logic [NE-1:0]    kill;
  logic [IDX_W-1:0] first;
  logic             found;
  int               rr_i;

  for (genvar g = 0; g < NE; g++) begin : g_kill
    if (g < NB) begin : g_blk
      assign kill[g] = 1'b0;
    end else begin : g_gen
      assign kill[g] = flush_en && vld[g] && (e_start[g] <= r_last) && (r_start <= e_last[g]);
    end
  end

  assign kept = vld & ~kill;

  always_comb begin
    found = 1'b0;
    first = '0;
    for (int i = NE - 1; i >= NB; i--) begin
      if (!kept[i]) begin
        found = 1'b1;
        first = IDX_W'(i);
      end
    end
    rr_i = int'(rr_q);
    if (rr_i < NB || rr_i >= NE) rr_i = NB;
    victim  = found ? first : IDX_W'(rr_i);
    use_rr  = !found;
    rr_next = (rr_i + 1 >= NE) ? IDX_W'(NB) : IDX_W'(rr_i + 1);
  end
endmodule

// File: rtl/range_tlb.sv
`timescale 1ns/1ps
module range_tlb
  import rtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NE        = 16,
  parameter int NB        = 4,
  parameter int LEN_W     = 16,
  localparam int IDX_W    = $clog2(NE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_va,
  input  logic [31:0]       cmd_aux,
  input  logic [63:0]       cmd_word,
  input  logic [IDX_W-1:0]  cmd_slot,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_err,
  input  logic [ADDR_W-1:0] lk_va,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [ADDR_W-1:0] lk_pa,
  output logic [30:0]       lk_acc_id,
  output logic [2:0]        lk_type,
  output logic [1:0]        lk_pl1,
  output logic [1:0]        lk_pl2,
  output logic [3:0]        lk_flags
);
  localparam logic [NE-1:0] BLK_MASK = {{(NE-NB){1'b0}}, {NB{1'b1}}};

  logic              rst_sn;
  op_e               op;
  logic [NE-1:0]     vld_q, vld_n, kept;
  logic              pend_q, pend_n, pend_ld;
  logic [ADDR_W-1:0] pend_start_q, pend_pa_q;
  logic [IDX_W-1:0]  rr_q, rr_n, victim, rr_next, wr_idx;
  logic              use_rr, wr_en, flush_en, slot_ok, prot_match;
  logic [ADDR_W-1:0] r_start, r_last, w_pa;
  rights_t           w_rt, lk_rt;
  logic [ADDR_W-1:0] e_start [NE];
  logic [ADDR_W-1:0] e_last  [NE];
  logic [ADDR_W-1:0] e_pa    [NE];
  rights_t           e_rt    [NE];

  assign op      = op_e'(cmd_op);
  assign slot_ok = int'(cmd_slot) < NB;
  assign cmd_err = cmd_valid && (op == OP_BLK_INS || op == OP_BLK_PURGE) && !slot_ok;

  rtlb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  rtlb_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)) u_dec (
    .op(op), .cmd_va(cmd_va), .cmd_aux(cmd_aux), .cmd_word(cmd_word), .cmd_len(cmd_len),
    .pend_q(pend_q), .pend_start(pend_start_q), .pend_pa(pend_pa_q),
    .r_start(r_start), .r_last(r_last), .w_pa(w_pa), .w_rt(w_rt), .prot_match(prot_match));

  assign flush_en = cmd_valid && (op == OP_LEG_ADDR || op == OP_SIZED || op == OP_PURGE ||
                                  (op == OP_LEG_PROT && prot_match) ||
                                  (op == OP_BLK_INS && slot_ok));

  rtlb_alloc #(.ADDR_W(ADDR_W), .NE(NE), .NB(NB), .IDX_W(IDX_W)) u_alloc (
    .vld(vld_q), .e_start(e_start), .e_last(e_last), .r_start(r_start), .r_last(r_last),
    .flush_en(flush_en), .rr_q(rr_q), .kept(kept), .victim(victim), .use_rr(use_rr),
    .rr_next(rr_next));

  rtlb_match #(.ADDR_W(ADDR_W), .NE(NE), .IDX_W(IDX_W)) u_match (
    .va(lk_va), .vld(vld_q), .e_start(e_start), .e_last(e_last), .e_pa(e_pa), .e_rt(e_rt),
    .hit(lk_hit), .idx(lk_idx), .pa(lk_pa), .rt(lk_rt));

  assign lk_acc_id = lk_rt.acc;
  assign lk_type   = lk_rt.typ;
  assign lk_pl1    = lk_rt.pl1;
  assign lk_pl2    = lk_rt.pl2;
  assign lk_flags  = {lk_rt.t, lk_rt.d, lk_rt.b, lk_rt.u};

  always_comb begin
    vld_n   = kept;
    pend_n  = pend_q;
    pend_ld = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = victim;
    rr_n    = rr_q;
    if (cmd_valid) begin
      unique case (op)
        OP_LEG_ADDR: begin
          pend_n  = 1'b1;
          pend_ld = 1'b1;
        end
        OP_LEG_PROT: begin
          pend_n = 1'b0;
          if (prot_match) begin
            wr_en = 1'b1;
            if (use_rr) rr_n = rr_next;
          end
        end
        OP_SIZED: begin
          wr_en = 1'b1;
          if (use_rr) rr_n = rr_next;
        end
        OP_PURGE_ALL: begin
          vld_n  = vld_q & BLK_MASK;
          pend_n = 1'b0;
          rr_n   = IDX_W'(NB);
        end
        OP_BLK_INS: begin
          if (slot_ok) begin
            wr_en  = 1'b1;
            wr_idx = cmd_slot;
          end
        end
        OP_BLK_PURGE: begin
          if (slot_ok) vld_n[cmd_slot] = 1'b0;
        end
        default: ;
      endcase
    end
    if (wr_en) vld_n[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q  <= '0;
      pend_q <= 1'b0;
      rr_q   <= IDX_W'(NB);
    end else begin
      vld_q  <= vld_n;
      pend_q <= pend_n;
      rr_q   <= rr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_ld) begin
      pend_start_q <= r_start;
      pend_pa_q    <= w_pa;
    end
  end

  for (genvar g = 0; g < NE; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        e_start[g] <= r_start;
        e_last[g]  <= r_last;
        e_pa[g]    <= w_pa;
        e_rt[g]    <= w_rt;
      end
    end
  end
endmodule

// File: rtl/range_tlb_chk.sv
`timescale 1ns/1ps
module range_tlb_chk #(
  parameter int NE    = 16,
  parameter int NB    = 4,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             cmd_err,
  input logic [NE-1:0]    vld,
  input logic [IDX_W-1:0] rr,
  input logic             pend,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx
);
  // R4: the rotating pointer always names a general slot
  p_rr_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rr) >= NB) && (int'(rr) < NE));

  // R9: purge-all empties the general slots and drops the pending step
  p_purge_all_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> (vld[NE-1:NB] == '0) && !pend);

  // R9: purge-all leaves block slots as they were
  p_blocks_survive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> (vld[NB-1:0] == $past(vld[NB-1:0])));

  // R11: a rejected block command changes no entry
  p_err_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> $stable(vld));

  // R1: a reported hit names a valid entry
  p_hit_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> vld[lk_idx]);

  // R5: a protection step always consumes the pending record
  p_prot_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> !pend);
endmodule

bind range_tlb range_tlb_chk #(.NE(NE), .NB(NB), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_err(cmd_err),
  .vld(vld_q), .rr(rr_q), .pend(pend_q), .lk_hit(lk_hit), .lk_idx(lk_idx));

// File: tb/sim_range_tlb.sv
`timescale 1ns/1ps
module sim_range_tlb;
  localparam int NE = 16;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_va, cmd_aux, lk_va, lk_pa;
  logic [63:0] cmd_word;
  logic [3:0]  cmd_slot, lk_idx, lk_flags;
  logic [15:0] cmd_len;
  logic        cmd_err, lk_hit;
  logic [30:0] lk_acc_id;
  logic [2:0]  lk_type;
  logic [1:0]  lk_pl1, lk_pl2;

  always #5 clk = ~clk;

  range_tlb u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_va(cmd_va),
    .cmd_aux(cmd_aux), .cmd_word(cmd_word), .cmd_slot(cmd_slot), .cmd_len(cmd_len),
    .cmd_err(cmd_err), .lk_va(lk_va), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pa(lk_pa),
    .lk_acc_id(lk_acc_id), .lk_type(lk_type), .lk_pl1(lk_pl1), .lk_pl2(lk_pl2),
    .lk_flags(lk_flags));

  // behavioural reference model
  logic [31:0] m_s [NE];
  logic [31:0] m_l [NE];
  logic [31:0] m_p [NE];
  logic        m_v [NE];
  logic [30:0] m_id [NE];
  logic [2:0]  m_ty [NE];
  logic [1:0]  m_p1 [NE];
  logic [1:0]  m_p2 [NE];
  logic [3:0]  m_fl [NE];
  int          m_rr;
  logic        m_pend;
  logic [31:0] m_ps, m_pp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] kmask(int k);
    if (12 + 2 * k >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << (12 + 2 * k)) - 32'h1;
  endfunction

  task automatic m_flush(logic [31:0] s, logic [31:0] l);
    for (int i = NB; i < NE; i++)
      if (m_v[i] && m_s[i] <= l && s <= m_l[i]) m_v[i] = 1'b0;
  endtask

  function automatic int m_alloc();
    int v;
    for (int i = NB; i < NE; i++) if (!m_v[i]) return i;
    v = m_rr;
    m_rr = (m_rr + 1 >= NE) ? NB : m_rr + 1;
    return v;
  endfunction

  task automatic m_put(int i, logic [31:0] s, logic [31:0] l, logic [31:0] p,
                       logic [30:0] id, logic [2:0] ty, logic [1:0] p1, logic [1:0] p2,
                       logic [3:0] fl);
    m_v[i] = 1'b1; m_s[i] = s; m_l[i] = l; m_p[i] = p;
    m_id[i] = id; m_ty[i] = ty; m_p1[i] = p1; m_p2[i] = p2; m_fl[i] = fl;
  endtask

  task automatic m_put_leg(int i, logic [31:0] s, logic [31:0] l, logic [31:0] p,
                           logic [31:0] w, bit blk);
    m_put(i, s, l, p, {13'd0, w[18:1]}, w[26:24], w[23:22], w[21:20],
          {blk ? 1'b0 : w[29], blk ? 1'b1 : w[28], w[27], w[19]});
  endtask

  task automatic model_update(int op, logic [31:0] va, logic [31:0] aux, logic [63:0] word,
                              int slot, int len);
    logic [31:0] s, l, p, m;
    longint      t;
    int          v;
    case (op)
      1: begin
        s = va & ~32'hFFF; l = s | 32'hFFF;
        m_flush(s, l);
        m_pend = 1'b1; m_ps = s; m_pp = {aux[24:5], 12'h000};
      end
      2: begin
        if (m_pend && (va & ~32'hFFF) == m_ps) begin
          m_flush(m_ps, m_ps | 32'hFFF);
          v = m_alloc();
          m_put_leg(v, m_ps, m_ps | 32'hFFF, m_pp, word[31:0], 1'b0);
        end
        m_pend = 1'b0;
      end
      3: begin
        m = kmask(int'(aux[3:0]));
        s = va & ~m; l = s | m; p = {aux[24:5], 12'h000} & ~m;
        m_flush(s, l);
        v = m_alloc();
        m_put(v, s, l, p, word[31:1], word[58:56], word[55:54], word[53:52],
              {word[61], word[60], word[59], word[51]});
      end
      4: begin
        m = kmask(int'(va[3:0]));
        s = va & ~32'hFFF;
        t = longint'(s) + longint'(m);
        l = (t > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : t[31:0];
        m_flush(s, l);
      end
      5: begin
        for (int i = NB; i < NE; i++) m_v[i] = 1'b0;
        m_rr = NB; m_pend = 1'b0;
      end
      6: if (slot < NB) begin
        s = va & ~32'hFFF; l = s + len * 4096 - 1;
        m_flush(s, l);
        m_put_leg(slot, s, l, {aux[19:0], 12'h000}, word[31:0], 1'b1);
      end
      7: if (slot < NB) m_v[slot] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic compare(string tag, int op, int slot);
    int f = -1;
    for (int i = 0; i < NE; i++)
      if (f < 0 && m_v[i] && lk_va >= m_s[i] && lk_va <= m_l[i]) f = i;
    chk(tag, "hit", lk_hit, f >= 0);
    chk(tag, "idx", lk_idx, f >= 0 ? f : 0);
    chk(tag, "pa", lk_pa, f >= 0 ? longint'(m_p[f] + (lk_va - m_s[f])) : 0);
    chk(tag, "acc_id", lk_acc_id, f >= 0 ? m_id[f] : 0);
    chk(tag, "type", lk_type, f >= 0 ? m_ty[f] : 0);
    chk(tag, "pl1", lk_pl1, f >= 0 ? m_p1[f] : 0);
    chk(tag, "pl2", lk_pl2, f >= 0 ? m_p2[f] : 0);
    chk(tag, "flags", lk_flags, f >= 0 ? m_fl[f] : 0);
    chk(tag, "err", cmd_err, (op == 6 || op == 7) && slot >= NB);
  endtask

  task automatic step(string tag, int op, logic [31:0] va, logic [31:0] aux,
                      logic [63:0] word, int slot, int len, logic [31:0] lva);
    @(negedge clk);
    cmd_valid = (op != 0);
    cmd_op = 3'(op); cmd_va = va; cmd_aux = aux; cmd_word = word;
    cmd_slot = 4'(slot); cmd_len = 16'(len); lk_va = lva;
    #1;
    compare(tag, op, slot);
    if (rst_n) model_update(op, va, aux, word, slot, len);
  endtask

  task automatic probe(string tag, logic [31:0] lva);
    step(tag, 0, 32'h0, 32'h0, 64'h0, 0, 0, lva);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  localparam logic [31:0] LW1 = 32'h2B5A_1234;
  localparam logic [31:0] LW2 = 32'h3CF0_ABCE;
  localparam logic [63:0] SW1 = 64'h3D5A_0000_8765_4321;
  localparam logic [63:0] SW2 = 64'h26A8_0000_1357_9BDF;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
    m_rr = NB; m_pend = 1'b0; m_ps = '0; m_pp = '0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_va = '0; cmd_aux = '0;
    cmd_word = '0; cmd_slot = '0; cmd_len = '0; lk_va = '0;
    repeat (3) @(posedge clk);
    // R13: nothing valid while in reset
    probe("R13", 32'h0000_0000);
    probe("R13", 32'h1234_5678);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) probe("R13", 32'hFFFF_F000);

    // R2 R7: 4 KiB sized insert; same-cycle lookup sees the old state (R12)
    step("R12", 3, 32'h1234_5678, (32'hABCDE << 5) | 32'd0, SW1, 0, 0, 32'h1234_5678);
    probe("R2", 32'h1234_5000);
    probe("R2", 32'h1234_5FFF);
    probe("R2", 32'h1234_6000);
    probe("R7", 32'h1234_4FFF);
    // R2: 64 KiB, base and address both aligned down
    step("R2", 3, 32'h2003_7ABC, (32'h11113 << 5) | 32'd2, SW2, 0, 0, 32'h0);
    probe("R2", 32'h2003_0000);
    probe("R2", 32'h2003_FFFF);
    probe("R2", 32'h2004_0000);
    probe("R2", 32'h2002_FFFF);
    probe("R2", 32'h2003_8123);
    // R2: largest size code saturates to the whole space
    step("R2", 3, 32'h0000_0000, (32'h00055 << 5) | 32'd15, SW1, 0, 0, 32'h0);
    probe("R2", 32'h0F00_0000);
    step("R8", 4, 32'h0000_000F, 0, 0, 0, 0, 32'h0F00_0000);
    probe("R8", 32'h0F00_0000);

    // R5 R6: legacy two-step insert
    step("R5", 1, 32'h4000_2345, 32'h0000_0777 << 5, 0, 0, 0, 32'h4000_2345);
    probe("R5", 32'h4000_2345);
    step("R6", 2, 32'h4000_2FF0, 0, {32'h0, LW1}, 0, 0, 32'h4000_2000);
    probe("R6", 32'h4000_2000);
    probe("R6", 32'h4000_2FFF);
    step("R5", 1, 32'h5000_0000, 32'h0000_0999 << 5, 0, 0, 0, 32'h0);
    step("R5", 2, 32'h5000_1000, 0, {32'h0, LW2}, 0, 0, 32'h5000_0000);
    probe("R5", 32'h5000_0000);
    step("R5", 2, 32'h5000_0000, 0, {32'h0, LW2}, 0, 0, 32'h5000_0000);
    probe("R5", 32'h5000_0000);

    // R10 R3: block insert over a general entry removes the general one
    step("R10", 6, 32'h2003_8000, 32'h0000_0042, {32'h0, LW1}, 1, 3, 32'h2003_8000);
    probe("R3", 32'h2003_0000);
    probe("R10", 32'h2003_8000);
    probe("R10", 32'h2003_AFFF);
    probe("R10", 32'h2003_B000);
    // R1 R3: general entry placed over a block slot; block kept and wins
    step("R10", 6, 32'h6000_0000, 32'h0000_0123, {32'h0, LW2}, 2, 2, 32'h0);
    step("R3", 3, 32'h6000_0000, (32'h00321 << 5) | 32'd1, SW1, 0, 0, 32'h6000_1000);
    probe("R1", 32'h6000_1000);
    probe("R1", 32'h6000_3000);
    probe("R3", 32'h6000_1FFF);

    // R4: fill every general slot and go past it
    for (int i = 0; i < 14; i++)
      step("R4", 3, 32'h7000_0000 + 32'(i) * 32'h1000, ((32'h70000 + 32'(i)) << 5), SW2,
           0, 0, 32'h7000_0000 + 32'(i) * 32'h1000);
    for (int i = 0; i < 14; i++) probe("R4", 32'h7000_0000 + 32'(i) * 32'h1000);
    for (int i = 0; i < 3; i++) probe("R4", 32'h1234_5000 + 32'(i) * 32'h0);
    // R8: purge one page, next insert takes the freed slot
    step("R8", 4, 32'h7000_5000, 0, 0, 0, 0, 32'h7000_5000);
    probe("R8", 32'h7000_5000);
    step("R4", 3, 32'h7100_0000, 32'h00011 << 5, SW1, 0, 0, 32'h0);
    probe("R4", 32'h7100_0000);
    // R8: range purge across a block region keeps the block
    step("R8", 4, 32'h6000_0001, 0, 0, 0, 0, 32'h6000_3000);
    probe("R8", 32'h6000_3000);
    probe("R8", 32'h6000_0000);

    // R9: purge-all cancels pending step, keeps blocks, resets pointer
    step("R9", 1, 32'h4100_0000, 32'h00AAA << 5, 0, 0, 0, 32'h0);
    step("R9", 5, 0, 0, 0, 0, 0, 32'h7000_0000);
    step("R9", 2, 32'h4100_0000, 0, {32'h0, LW1}, 0, 0, 32'h7000_0000);
    probe("R9", 32'h4100_0000);
    probe("R9", 32'h7000_0000);
    probe("R9", 32'h2003_9000);
    for (int i = 0; i < 13; i++)
      step("R9", 3, 32'h8000_0000 + 32'(i) * 32'h1000, ((32'h80000 + 32'(i)) << 5), SW1,
           0, 0, 32'h8000_0000);
    for (int i = 0; i < 13; i++) probe("R9", 32'h8000_0000 + 32'(i) * 32'h1000);

    // R11: block purge, then out-of-range slots rejected
    step("R11", 7, 0, 0, 0, 1, 0, 32'h2003_9000);
    probe("R11", 32'h2003_9000);
    step("R11", 6, 32'h9000_0000, 32'h0000_0111, {32'h0, LW1}, 4, 1, 32'h6000_0000);
    probe("R11", 32'h9000_0000);
    step("R11", 7, 0, 0, 0, 9, 0, 32'h6000_0000);
    probe("R11", 32'h6000_0000);
    step("R12", 7, 0, 0, 0, 2, 0, 32'h6000_0000);
    probe("R12", 32'h6000_0000);

    done = 1;
    summary();
    $finish;
  end
endmodule